// File: doc/BRIEF.md
# MONITOR Channel Handshake Controller

This block moves multi-byte messages across the MONITOR timeslot of a framed serial bus. Once per frame the bus offers one data byte plus two active-low flags. The transmit-valid flag (MX) marks a byte on offer. The receive-acknowledge flag (MR) answers it. The block sees the timeslot as a one-cycle `frame_tick` strobe. It samples the incoming slot on that strobe and updates its outgoing slot on the same edge, so each outgoing value holds for a whole frame. Serial clocking and the other timeslots are handled elsewhere.

On the transmit side, a CPU loads bytes into a holding register and keeps an MX-control level set for the length of the message. Each byte stays on the bus with MX low, frame after frame, until the peer acknowledges it. When the CPU drops the MX-control level after the last byte, MX goes high for two frames and the message ends. On the receive side, a byte is accepted only after it is seen twice in a row. The block acknowledges each accepted byte on MR and flags the end of a message. When the two samples disagree, it signals an abort on MR. Each interrupt source has its own enable. Interrupts are one-cycle pulses that follow the frame tick.

Top module: `mon_handshake`

## Requirements
- R1: After reset, and whenever `tx_active` is 0, `bus_mx_out` is 1. After reset, `bus_mr_out` is 1, `bus_data_out` is 8'hFF and `tx_active` is 0.
- R2: The outgoing slot changes only at a frame tick. A message starts at the first tick at which `cpu_tx_ie`=1, `cpu_mx_ctl`=1 and a written byte is pending. After that tick, `bus_data_out` carries the byte, `bus_mx_out` is 0 and `tx_active` is 1.
- R3: The byte and MX stay unchanged at every tick until MR (`bus_mr_in`) is sampled 0 at one tick and 1 at the next.
- R4: That MR rising edge acknowledges the byte and raises a one-cycle `ack_irq`. If a new byte is pending and `cpu_mx_ctl`=1, the new byte goes out at the same tick with MX kept at 0. Otherwise MX goes to 1 and the data goes to 8'hFF. A byte written while MX is 1 and `cpu_mx_ctl`=1 goes out at the next tick.
- R5: Once MX is 1 after an acknowledge and `cpu_mx_ctl` is 0 at a tick, `tx_active` falls at the following tick, so MX is high for two frames.
- R6: MR sampled 0 at two consecutive ticks while a byte is on offer aborts the message. This raises a one-cycle `abort_irq`, sets MX to 1, clears `tx_active` and discards any pending byte.
- R7: With `cpu_tx_ie`=0, `ack_irq` and `abort_irq` stay 0, while the handshake itself still advances.
- R8: With `cpu_mr_ctl`=1, a byte seen with MX=0 at two consecutive ticks is accepted, provided it differs from the last accepted byte of the message. Acceptance updates `rx_byte` and raises `rx_data_irq`, and `bus_mr_out` goes 0 for exactly one frame.
- R9: A byte equal to the last accepted byte of the current message is ignored.
- R10: Two differing consecutive bytes with MX=0 raise `abort_irq` (when `cpu_tx_ie`=1) instead of an accept, and drive `bus_mr_out` to 0 for two frames.
- R11: MX sampled 1 at two consecutive ticks after at least one accepted byte raises `rx_end_irq` and ends the message. A following byte equal to the former last byte is accepted again.
- R12: With `cpu_mr_ctl`=0, nothing is accepted, `rx_byte` keeps its value and `bus_mr_out` stays 1.
- R13: `cpu_rx_data_ie` and `cpu_rx_end_ie` each mask only their own interrupt. The handshake still runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle strobe per bus frame |
| bus_data_in | input | 8 | Incoming MONITOR byte |
| bus_mx_in | input | 1 | Incoming MX flag, active low |
| bus_mr_in | input | 1 | Incoming MR flag, active low |
| bus_data_out | output | 8 | Outgoing MONITOR byte |
| bus_mx_out | output | 1 | Outgoing MX flag, active low |
| bus_mr_out | output | 1 | Outgoing MR flag, active low |
| cpu_tx_data | input | 8 | Byte to send |
| cpu_tx_wr | input | 1 | Write strobe for `cpu_tx_data` |
| cpu_mx_ctl | input | 1 | MX-control level, kept at 1 for the length of a message |
| cpu_mr_ctl | input | 1 | Receive enable / MR control |
| cpu_tx_ie | input | 1 | Transmit interrupt enable (acknowledge and abort) |
| cpu_rx_data_ie | input | 1 | Data-received interrupt enable |
| cpu_rx_end_ie | input | 1 | End-of-reception interrupt enable |
| tx_active | output | 1 | Transmit message in progress |
| ack_irq | output | 1 | Byte acknowledged pulse |
| abort_irq | output | 1 | Abort pulse |
| rx_data_irq | output | 1 | Byte received pulse |
| rx_end_irq | output | 1 | End of received message pulse |
| rx_byte | output | 8 | Last accepted byte |

## Verification
A stuck transmit state shows at the next frame tick. Either the outgoing byte fails to advance after an MR edge, or it changes without one. A stale `tx_active` shows two ticks after the MX-control level drops. Receive errors surface on MR within one frame: a missing, extra or one-frame-too-long low pulse. A wrong candidate or last-byte register shows as a missing or duplicated `rx_data_irq` on the tick of the second matching sample. A lost end-of-message flag shows when a repeated byte is not accepted in the next message.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_GAP  = 2'd2,
    TX_END  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/mon_tx.sv
module mon_tx
  import mon_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              mr_in,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_wr,
  input  logic              mx_ctl,
  input  logic              tx_ie,
  output logic [DATA_W-1:0] data_out,
  output logic              mx_out,
  output logic              active,
  output logic              ack_evt,
  output logic              abort_evt
);
  localparam logic [DATA_W-1:0] IDLE_PAT = '1;

  tx_state_t         st;
  logic [DATA_W-1:0] hold;
  logic              hold_v;
  logic              mr_prev;

  // named events for the assertions
  logic mr_edge, mr_hold_low, start_ok;
  assign mr_edge     = frame_tick & ~mr_prev & mr_in;
  assign mr_hold_low = frame_tick & ~mr_prev & ~mr_in;
  assign start_ok    = tx_ie & mx_ctl & hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= TX_IDLE;
      hold      <= '0;
      hold_v    <= 1'b0;
      mr_prev   <= 1'b1;
      data_out  <= IDLE_PAT;
      mx_out    <= 1'b1;
      active    <= 1'b0;
      ack_evt   <= 1'b0;
      abort_evt <= 1'b0;
    end else begin
      ack_evt   <= 1'b0;
      abort_evt <= 1'b0;
      if (tx_wr) begin
        hold   <= tx_data;
        hold_v <= 1'b1;
      end
      if (frame_tick) begin
        mr_prev <= mr_in;
        unique case (st)
          TX_IDLE: if (start_ok) begin
            data_out <= hold;
            mx_out   <= 1'b0;
            active   <= 1'b1;
            st       <= TX_SEND;
            if (!tx_wr) hold_v <= 1'b0;
          end
          TX_SEND: begin
            if (mr_edge) begin
              ack_evt <= 1'b1;
              if (mx_ctl && hold_v) begin
                data_out <= hold;
                if (!tx_wr) hold_v <= 1'b0;
              end else begin
                data_out <= IDLE_PAT;
                mx_out   <= 1'b1;
                st       <= TX_GAP;
              end
            end else if (mr_hold_low) begin
              abort_evt <= 1'b1;
              data_out  <= IDLE_PAT;
              mx_out    <= 1'b1;
              active    <= 1'b0;
              st        <= TX_IDLE;
              if (!tx_wr) hold_v <= 1'b0;
            end
          end
          TX_GAP: begin
            if (!mx_ctl) begin
              st <= TX_END;
            end else if (hold_v) begin
              data_out <= hold;
              mx_out   <= 1'b0;
              st       <= TX_SEND;
              if (!tx_wr) hold_v <= 1'b0;
            end
          end
          TX_END: begin
            active <= 1'b0;
            st     <= TX_IDLE;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  // R2: outgoing slot only moves on a frame tick
  a_r2_slot_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(data_out) && $stable(mx_out));

  // R1: MX stays high while no message is active
  a_r1_idle_mx_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> mx_out);

  // R4: an acknowledge follows a tick on which MR was sampled high
  a_r4_ack_on_mr_high: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |-> $past(frame_tick) && $past(mr_in));

  // R5/R6: when the message ends, MX is already high
  a_r5_end_mx_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> mx_out);

  // R6: an abort follows a tick on which MR was sampled low
  a_r6_abort_on_mr_low: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> $past(frame_tick) && !$past(mr_in));
endmodule

// File: rtl/mon_rx.sv
module mon_rx #(
  parameter int DATA_W     = 8,
  parameter int ACK_FRAMES = 1,
  parameter int ABT_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [DATA_W-1:0] data_in,
  input  logic              mx_in,
  input  logic              mr_ctl,
  output logic              mr_out,
  output logic [DATA_W-1:0] rx_byte,
  output logic              new_evt,
  output logic              end_evt,
  output logic              abort_evt
);
  localparam int CW = $clog2(ABT_FRAMES + 1);

  logic [DATA_W-1:0] cand, last;
  logic              cand_v, last_v, mx_hi_prev;
  logic [CW-1:0]     mr_cnt;

  // named events for the assertions
  logic differs, match;
  assign differs = ~last_v | (data_in != last);
  assign match   = cand_v & (data_in == cand);
  assign mr_out  = (mr_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand       <= '0;
      last       <= '0;
      cand_v     <= 1'b0;
      last_v     <= 1'b0;
      mx_hi_prev <= 1'b0;
      mr_cnt     <= '0;
      rx_byte    <= '0;
      new_evt    <= 1'b0;
      end_evt    <= 1'b0;
      abort_evt  <= 1'b0;
    end else begin
      new_evt   <= 1'b0;
      end_evt   <= 1'b0;
      abort_evt <= 1'b0;
      if (frame_tick) begin
        if (mr_cnt != '0) mr_cnt <= mr_cnt - 1'b1;
        if (!mr_ctl) begin
          cand_v     <= 1'b0;
          last_v     <= 1'b0;
          mx_hi_prev <= 1'b0;
        end else if (mx_in) begin
          cand_v     <= 1'b0;
          mx_hi_prev <= 1'b1;
          if (mx_hi_prev && last_v) begin
            end_evt <= 1'b1;
            last_v  <= 1'b0;
          end
        end else begin
          mx_hi_prev <= 1'b0;
          if (cand_v) begin
            cand_v <= 1'b0;
            if (match) begin
              rx_byte <= cand;
              last    <= cand;
              last_v  <= 1'b1;
              new_evt <= 1'b1;
              mr_cnt  <= CW'(ACK_FRAMES);
            end else begin
              abort_evt <= 1'b1;
              mr_cnt    <= CW'(ABT_FRAMES);
            end
          end else if (differs) begin
            cand   <= data_in;
            cand_v <= 1'b1;
          end
        end
      end
    end
  end

  // R8: an accepted byte is acknowledged on MR at once
  a_r8_ack_drives_mr: assert property (@(posedge clk) disable iff (!rst_n)
    new_evt |-> !mr_out);

  // R10: a mismatch abort is signalled on MR
  a_r10_abort_drives_mr: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |-> !mr_out);

  // R8: an accept never coincides with an abort
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({new_evt, abort_evt, end_evt}) <= 1);

  // R12: receiver disabled at a tick gives no accept after it
  a_r12_off_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick && !mr_ctl |=> !new_evt && !abort_evt && !end_evt);
endmodule

// File: rtl/mon_handshake.sv
module mon_handshake #(
  parameter int DATA_W     = 8,
  parameter int ACK_FRAMES = 1,
  parameter int ABT_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [DATA_W-1:0] bus_data_in,
  input  logic              bus_mx_in,
  input  logic              bus_mr_in,
  output logic [DATA_W-1:0] bus_data_out,
  output logic              bus_mx_out,
  output logic              bus_mr_out,
  input  logic [DATA_W-1:0] cpu_tx_data,
  input  logic              cpu_tx_wr,
  input  logic              cpu_mx_ctl,
  input  logic              cpu_mr_ctl,
  input  logic              cpu_tx_ie,
  input  logic              cpu_rx_data_ie,
  input  logic              cpu_rx_end_ie,
  output logic              tx_active,
  output logic              ack_irq,
  output logic              abort_irq,
  output logic              rx_data_irq,
  output logic              rx_end_irq,
  output logic [DATA_W-1:0] rx_byte
);
  logic tx_ack_evt, tx_abort_evt;
  logic rx_new_evt, rx_end_evt, rx_abort_evt;

  mon_tx #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .mr_in     (bus_mr_in),
    .tx_data   (cpu_tx_data),
    .tx_wr     (cpu_tx_wr),
    .mx_ctl    (cpu_mx_ctl),
    .tx_ie     (cpu_tx_ie),
    .data_out  (bus_data_out),
    .mx_out    (bus_mx_out),
    .active    (tx_active),
    .ack_evt   (tx_ack_evt),
    .abort_evt (tx_abort_evt)
  );

  mon_rx #(
    .DATA_W    (DATA_W),
    .ACK_FRAMES(ACK_FRAMES),
    .ABT_FRAMES(ABT_FRAMES)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .data_in   (bus_data_in),
    .mx_in     (bus_mx_in),
    .mr_ctl    (cpu_mr_ctl),
    .mr_out    (bus_mr_out),
    .rx_byte   (rx_byte),
    .new_evt   (rx_new_evt),
    .end_evt   (rx_end_evt),
    .abort_evt (rx_abort_evt)
  );

  assign ack_irq     = tx_ack_evt & cpu_tx_ie;
  assign abort_irq   = (tx_abort_evt | rx_abort_evt) & cpu_tx_ie;
  assign rx_data_irq = rx_new_evt & cpu_rx_data_ie;
  assign rx_end_irq  = rx_end_evt & cpu_rx_end_ie;

  // R13: interrupts are single-cycle pulses
  a_r13_pulse_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data_irq |=> !rx_data_irq);
  a_r4_pulse_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_irq |=> !ack_irq);
endmodule

// File: tb/mon_handshake_tb.sv
module mon_handshake_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [7:0] bus_data_in = 8'hFF;
  logic       bus_mx_in = 1'b1;
  logic       bus_mr_in = 1'b1;
  logic [7:0] bus_data_out;
  logic       bus_mx_out, bus_mr_out;
  logic [7:0] cpu_tx_data = 8'h00;
  logic       cpu_tx_wr = 1'b0, cpu_mx_ctl = 1'b0, cpu_mr_ctl = 1'b0;
  logic       cpu_tx_ie = 1'b0, cpu_rx_data_ie = 1'b0, cpu_rx_end_ie = 1'b0;
  logic       tx_active, ack_irq, abort_irq, rx_data_irq, rx_end_irq;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  logic p_ack, p_abort, p_rxd, p_end;

  always #4 clk = ~clk;

  mon_handshake u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus frame: present the incoming slot, strobe, capture pulses
  task automatic frame(input logic mx, input logic [7:0] d, input logic mr);
    @(negedge clk);
    bus_mx_in = mx; bus_data_in = d; bus_mr_in = mr; frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    p_ack = ack_irq; p_abort = abort_irq; p_rxd = rx_data_irq; p_end = rx_end_irq;
    @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] v);
    @(negedge clk);
    cpu_tx_data = v; cpu_tx_wr = 1'b1;
    @(negedge clk);
    cpu_tx_wr = 1'b0;
  endtask

  function automatic logic [7:0] next_distinct(input logic [7:0] prev, input logic [31:0] r);
    logic [7:0] v;
    v = r[7:0];
    if (v == prev) v = v ^ 8'h5A;
    return v;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    logic [7:0] b;
    int cnt;
    int holdn;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 mx", bus_mx_out, 1'b1);
    check("R1 mr", bus_mr_out, 1'b1);
    check("R1 data", bus_data_out, 8'hFF);
    check("R1 active", tx_active, 1'b0);

    // R2 start
    cpu_tx_ie = 1'b1; cpu_mx_ctl = 1'b1;
    cpu_write(8'h3C);
    check("R2 no change before tick", bus_mx_out, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R2 mx low", bus_mx_out, 1'b0);
    check("R2 data", bus_data_out, 8'h3C);
    check("R2 active", tx_active, 1'b1);
    // R3 hold
    for (int i = 0; i < 3; i++) begin
      frame(1'b1, 8'hFF, 1'b1);
      check("R3 held data", bus_data_out, 8'h3C);
      check("R3 held mx", bus_mx_out, 1'b0);
    end
    frame(1'b1, 8'hFF, 1'b0);
    check("R3 no ack on low", p_ack, 1'b0);
    check("R3 held after low", bus_data_out, 8'h3C);
    // R4 ack, nothing pending
    frame(1'b1, 8'hFF, 1'b1);
    check("R4 ack pulse", p_ack, 1'b1);
    check("R4 mx high", bus_mx_out, 1'b1);
    check("R4 idle data", bus_data_out, 8'hFF);
    cpu_write(8'hA5);
    frame(1'b1, 8'hFF, 1'b1);
    check("R4 gap load mx", bus_mx_out, 1'b0);
    check("R4 gap load data", bus_data_out, 8'hA5);
    // R4 ack with pending byte
    cpu_write(8'h5A);
    frame(1'b1, 8'hFF, 1'b0);
    frame(1'b1, 8'hFF, 1'b1);
    check("R4 ack2", p_ack, 1'b1);
    check("R4 continuous mx", bus_mx_out, 1'b0);
    check("R4 continuous data", bus_data_out, 8'h5A);
    // R5 end
    cpu_mx_ctl = 1'b0;
    frame(1'b1, 8'hFF, 1'b0);
    frame(1'b1, 8'hFF, 1'b1);
    check("R5 last ack", p_ack, 1'b1);
    check("R5 active gap", tx_active, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R5 active first high", tx_active, 1'b1);
    check("R5 mx high", bus_mx_out, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R5 active cleared", tx_active, 1'b0);

    // R7 masked ack
    cpu_mx_ctl = 1'b1;
    cpu_write(8'h11);
    frame(1'b1, 8'hFF, 1'b1);
    check("R7 started", tx_active, 1'b1);
    cpu_tx_ie = 1'b0;
    frame(1'b1, 8'hFF, 1'b0);
    frame(1'b1, 8'hFF, 1'b1);
    check("R7 ack masked", p_ack, 1'b0);
    check("R7 handshake advanced", bus_mx_out, 1'b1);
    cpu_mx_ctl = 1'b0;
    frame(1'b1, 8'hFF, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R7 ended", tx_active, 1'b0);

    // R6 abort
    cpu_tx_ie = 1'b1; cpu_mx_ctl = 1'b1;
    cpu_write(8'h22);
    frame(1'b1, 8'hFF, 1'b1);
    cpu_write(8'h33);
    frame(1'b1, 8'hFF, 1'b0);
    frame(1'b1, 8'hFF, 1'b0);
    check("R6 abort pulse", p_abort, 1'b1);
    check("R6 ack absent", p_ack, 1'b0);
    check("R6 inactive", tx_active, 1'b0);
    check("R6 mx high", bus_mx_out, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R6 pending discarded", bus_mx_out, 1'b1);
    check("R6 stays idle", tx_active, 1'b0);
    // R7 masked abort
    cpu_write(8'h44);
    frame(1'b1, 8'hFF, 1'b1);
    cpu_tx_ie = 1'b0;
    frame(1'b1, 8'hFF, 1'b0);
    frame(1'b1, 8'hFF, 1'b0);
    check("R7 abort masked", p_abort, 1'b0);
    check("R7 aborted anyway", tx_active, 1'b0);
    cpu_mx_ctl = 1'b0; cpu_tx_ie = 1'b1;

    // R8 receive
    cpu_mr_ctl = 1'b1; cpu_rx_data_ie = 1'b1; cpu_rx_end_ie = 1'b1;
    frame(1'b0, 8'h47, 1'b1);
    check("R8 not yet", p_rxd, 1'b0);
    check("R8 mr idle", bus_mr_out, 1'b1);
    frame(1'b0, 8'h47, 1'b1);
    check("R8 accept pulse", p_rxd, 1'b1);
    check("R8 rx_byte", rx_byte, 8'h47);
    check("R8 mr low", bus_mr_out, 1'b0);
    frame(1'b0, 8'h47, 1'b1);
    check("R9 repeat ignored", p_rxd, 1'b0);
    check("R8 mr one frame", bus_mr_out, 1'b1);
    frame(1'b0, 8'h47, 1'b1);
    check("R9 repeat ignored 2", p_rxd, 1'b0);
    // R10 mismatch
    frame(1'b0, 8'h61, 1'b1);
    frame(1'b0, 8'h62, 1'b1);
    check("R10 abort pulse", p_abort, 1'b1);
    check("R10 no accept", p_rxd, 1'b0);
    check("R10 mr low", bus_mr_out, 1'b0);
    frame(1'b1, 8'hFF, 1'b1);
    check("R10 mr low second", bus_mr_out, 1'b0);
    frame(1'b1, 8'hFF, 1'b1);
    check("R10 mr released", bus_mr_out, 1'b1);
    check("R11 end pulse", p_end, 1'b1);
    check("R10 rx_byte kept", rx_byte, 8'h47);
    frame(1'b0, 8'h47, 1'b1);
    frame(1'b0, 8'h47, 1'b1);
    check("R11 reaccept", p_rxd, 1'b1);
    // R13 masks
    cpu_rx_data_ie = 1'b0;
    frame(1'b0, 8'h55, 1'b1);
    frame(1'b0, 8'h55, 1'b1);
    check("R13 data masked", p_rxd, 1'b0);
    check("R13 byte still taken", rx_byte, 8'h55);
    check("R13 mr still acks", bus_mr_out, 1'b0);
    cpu_rx_data_ie = 1'b1; cpu_rx_end_ie = 1'b0;
    frame(1'b1, 8'hFF, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R13 end masked", p_end, 1'b0);
    cpu_rx_end_ie = 1'b1;
    // R12 receiver off
    cpu_mr_ctl = 1'b0;
    frame(1'b0, 8'h77, 1'b1);
    frame(1'b0, 8'h77, 1'b1);
    check("R12 no pulse", p_rxd, 1'b0);
    check("R12 mr high", bus_mr_out, 1'b1);
    check("R12 byte kept", rx_byte, 8'h55);

    // random receive messages
    cpu_mr_ctl = 1'b1;
    for (int m = 0; m < 20; m++) begin
      int len;
      len = 1 + int'($urandom % 5);
      prev = 8'hFF;
      for (int k = 0; k < len; k++) begin
        b = next_distinct(prev, $urandom);
        prev = b;
        cnt = 0;
        holdn = 2 + int'($urandom % 3);
        for (int f = 0; f < holdn; f++) begin
          frame(1'b0, b, 1'b1);
          if (p_rxd) cnt++;
        end
        check("R8 random one accept", cnt, 1);
        check("R8 random byte", rx_byte, b);
      end
      frame(1'b1, 8'hFF, 1'b1);
      frame(1'b1, 8'hFF, 1'b1);
      check("R11 random end", p_end, 1'b1);
    end
    cpu_mr_ctl = 1'b0;

    // random transmit message
    cpu_tx_ie = 1'b1; cpu_mx_ctl = 1'b1;
    for (int k = 0; k < 15; k++) begin
      b = 8'($urandom);
      cpu_write(b);
      frame(1'b1, 8'hFF, 1'b1);
      check("R2 random tx data", bus_data_out, b);
      check("R2 random tx mx", bus_mx_out, 1'b0);
      holdn = int'($urandom % 4);
      for (int f = 0; f < holdn; f++) begin
        frame(1'b1, 8'hFF, 1'b1);
        check("R3 random hold", bus_data_out, b);
      end
      frame(1'b1, 8'hFF, 1'b0);
      frame(1'b1, 8'hFF, 1'b1);
      check("R4 random ack", p_ack, 1'b1);
    end
    cpu_mx_ctl = 1'b0;
    frame(1'b1, 8'hFF, 1'b1);
    frame(1'b1, 8'hFF, 1'b1);
    check("R5 random end", tx_active, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule